// File: doc/BRIEF.md
# Iterative Booth Multiply-Accumulate Unit

This unit multiplies two 32-bit integers over several clock cycles. It can also add an accumulator value to the product. The multiplier operand is recoded two bits at a time using radix-4 Booth recoding. Each clock cycle retires one recoded chunk. The chunk selects zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. That selection goes through one shared adder into a running sum. After each chunk, the multiplicand moves two places left and the multiplier moves two places right, keeping its sign.

The loop ends as soon as the multiplier bits still waiting give no further terms. This happens when they are all zero with a zero previous bit, or all one with a one previous bit. Small or small-negative multipliers therefore finish in a few cycles. The worst case is sixteen chunks.

A caller raises a start strobe with the operands while the unit is idle. Later it receives a one-cycle done pulse. The pulse comes with the low 32 bits of the result, the number of chunks used, and the final value of a carry bit that is kept beside the running sum.

Top module: `booth_mac`

## Requirements
- R1: When done is high, `result_o` equals the low W bits of `mcand_i * mplier_i`, plus `acc_i` if `acc_en_i` was high when the operation started. Operands are treated as two's complement and arithmetic is modulo 2^W.
- R2: One recoded chunk is retired per clock. `done_o` rises exactly `cycles_o + 1` rising edges after the edge that samples an accepted start.
- R3: `cycles_o` equals the number of chunks processed before the remaining multiplier and previous bit reach the exit state. The exit state is all zeros with previous bit 0, or all ones with previous bit 1. The previous bit starts at 0, and the count never exceeds W/2 (16). Examples: a multiplier of 0 gives 0 cycles, -1 gives 1, and 0x80000000 gives 16.
- R4: Chunk codes {m[1],m[0],prev} map as follows: 001 and 010 select +M, 011 selects +2M, 100 selects -2M, 101 and 110 select -M, and 000 and 111 select nothing. Subtraction adds the inverted term plus one. `carry_o` is the carry out of bit W-1 of the last addition that took place, or 0 when no addition took place.
- R5: `done_o` is high for exactly one cycle. `busy_o` is high from the edge after an accepted start until the finishing edge. `busy_o` and `done_o` are never high together.
- R6: A start strobe while `busy_o` is high is ignored. The running operation completes with its own operands.
- R7: After reset, `busy_o`, `done_o`, `result_o`, `carry_o` and `cycles_o` are all zero.
- R8: With `acc_en_i` low, the value on `acc_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| mcand_i | input | W (32) | Multiplicand |
| mplier_i | input | W (32) | Multiplier, Booth-recoded |
| acc_i | input | W (32) | Accumulator seed |
| acc_en_i | input | 1 | Seed the sum with acc_i (multiply-accumulate) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W (32) | Low W bits of the result, held after done |
| carry_o | output | 1 | Carry bit after the final addition |
| cycles_o | output | CW (5) | Chunks processed by the last operation |

## Verification
The bench targets these corner cases:

- **Multiplier 0.** It must finish after zero chunks. A design that tested for exit only after the first chunk would report one cycle.
- **Multiplier -1.** It needs exactly one subtracting chunk. A design that ignored the previous bit in the exit test would stop at once with a zero result.
- **Multiplier 0x80000000.** It runs the full sixteen chunks with a final minus-2M term. A design that miscounted or wrapped the counter would give a wrong count or product.
- **Carry bit.** It is checked against an independent add-by-add model. An adder that dropped the plus-one of subtraction, or cleared the carry on zero chunks, would show a mismatch.
- **Accumulator and start strobes.** Accumulate is exercised with the enable both high and low. A start strobe is also injected mid-operation: reloading on it would corrupt the result.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Term picked by one radix-4 chunk
  typedef enum logic [2:0] {
    SEL_ZERO = 3'd0,
    SEL_P1   = 3'd1,
    SEL_P2   = 3'd2,
    SEL_M1   = 3'd3,
    SEL_M2   = 3'd4
  } term_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mac_state_e;
endpackage

// File: rtl/booth_scan.sv
module booth_scan
  import booth_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic         prev_i,
  output term_sel_e    sel_o,
  output logic         exit_o
);
  // Nothing left to add: pure sign extension of the previous bit
  assign exit_o = prev_i ? (&rem_i) : ~(|rem_i);

  always_comb begin
    unique case ({rem_i[1:0], prev_i})
      3'b001, 3'b010: sel_o = SEL_P1;
      3'b011:         sel_o = SEL_P2;
      3'b100:         sel_o = SEL_M2;
      3'b101, 3'b110: sel_o = SEL_M1;
      default:        sel_o = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/booth_addpath.sv
module booth_addpath
  import booth_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] sum_i,
  input  logic         carry_i,
  input  logic [W-1:0] mc_i,
  input  term_sel_e    sel_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] opnd;
  logic         neg;
  logic         act;
  logic         cout;
  logic [W-1:0] mc2;

  assign mc2 = {mc_i[W-2:0], 1'b0};

  // One shared adder; subtraction via inverted operand plus carry-in
  always_comb begin
    opnd = '0;
    neg  = 1'b0;
    act  = 1'b1;
    unique case (sel_i)
      SEL_P1:  opnd = mc_i;
      SEL_P2:  opnd = mc2;
      SEL_M1:  begin opnd = ~mc_i; neg = 1'b1; end
      SEL_M2:  begin opnd = ~mc2;  neg = 1'b1; end
      default: act = 1'b0;
    endcase
    {cout, sum_o} = {1'b0, sum_i} + {1'b0, opnd} + {{W{1'b0}}, neg};
    carry_o = act ? cout : carry_i;
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int NCHUNK = 16,
  localparam int CW = $clog2(NCHUNK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          exit_i,
  output logic          load_o,
  output logic          step_o,
  output logic          fin_o,
  output logic          busy_o,
  output logic [CW-1:0] count_o
);
  mac_state_e    state_q;
  logic [CW-1:0] count_q;
  logic          at_cap;

  assign at_cap  = (count_q == CW'(NCHUNK));
  assign busy_o  = (state_q == ST_RUN);
  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign fin_o   = busy_o && (exit_i || at_cap);
  assign step_o  = busy_o && !fin_o;
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      count_q <= '0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      count_q <= '0;
    end else if (fin_o) begin
      state_q <= ST_IDLE;
    end else if (step_o) begin
      count_q <= count_q + 1'b1;
    end
  end

  a_r3_count_cap: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(NCHUNK))
    else $error("R3 chunk count above limit");

  a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
    step_o |=> (count_q == $past(count_q) + 1'b1))
    else $error("R2 count did not advance by one chunk");
endmodule

// File: rtl/booth_mac.sv
module booth_mac
  import booth_pkg::*;
#(
  parameter int W = 32,
  localparam int NCHUNK = W / 2,
  localparam int CW = $clog2(NCHUNK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  input  logic [W-1:0]  acc_i,
  input  logic          acc_en_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  result_o,
  output logic          carry_o,
  output logic [CW-1:0] cycles_o
);
  logic [W-1:0]  sum_q, mc_q, rem_q, sum_n;
  logic          prev_q, carry_q, carry_n;
  logic          load, step, fin, exit_hit;
  logic [CW-1:0] count;
  term_sel_e     sel;

  booth_scan #(.W(W)) u_scan (
    .rem_i (rem_q),
    .prev_i(prev_q),
    .sel_o (sel),
    .exit_o(exit_hit)
  );

  booth_addpath #(.W(W)) u_add (
    .sum_i  (sum_q),
    .carry_i(carry_q),
    .mc_i   (mc_q),
    .sel_i  (sel),
    .sum_o  (sum_n),
    .carry_o(carry_n)
  );

  booth_ctrl #(.NCHUNK(NCHUNK)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .exit_i (exit_hit),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin),
    .busy_o (busy_o),
    .count_o(count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      mc_q    <= '0;
      rem_q   <= '0;
      prev_q  <= 1'b0;
      carry_q <= 1'b0;
    end else if (load) begin
      sum_q   <= acc_en_i ? acc_i : '0;
      mc_q    <= mcand_i;
      rem_q   <= mplier_i;
      prev_q  <= 1'b0;
      carry_q <= 1'b0;
    end else if (step) begin
      sum_q   <= sum_n;
      carry_q <= carry_n;
      mc_q    <= {mc_q[W-3:0], 2'b00};
      rem_q   <= {{2{rem_q[W-1]}}, rem_q[W-1:2]};
      prev_q  <= rem_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      result_o <= '0;
      carry_o  <= 1'b0;
      cycles_o <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        result_o <= sum_q;
        carry_o  <= carry_q;
        cycles_o <= count;
      end
    end
  end

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o)
    else $error("R5 done held longer than one cycle");

  a_r5_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_o, done_o}))
    else $error("R5 busy and done together");

  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o)
    else $error("R5 start accepted but not busy");

  a_r6_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !fin && start_i) |=> (rem_q == {{2{$past(rem_q[W-1])}}, $past(rem_q[W-1:2])}))
    else $error("R6 multiplier reloaded while busy");

  a_r4_carry_clear: assert property (@(posedge clk) disable iff (rst)
    load |=> !carry_q)
    else $error("R4 carry not cleared at start");

  a_r3_exit_ends: assert property (@(posedge clk) disable iff (rst)
    (busy_o && exit_hit) |=> (done_o && !busy_o))
    else $error("R3 exit state did not end the operation");
endmodule

// File: tb/booth_mac_bench.sv
module booth_mac_bench;
  localparam int W  = 32;
  localparam int CW = $clog2(W / 2 + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [W-1:0]  mcand_i = '0, mplier_i = '0, acc_i = '0;
  logic          acc_en_i = 1'b0;
  logic          busy_o, done_o, carry_o;
  logic [W-1:0]  result_o;
  logic [CW-1:0] cycles_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  booth_mac #(.W(W)) u_booth_mac (
    .clk(clk), .rst(rst), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .acc_i(acc_i), .acc_en_i(acc_en_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .carry_o(carry_o), .cycles_o(cycles_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Chunk-by-chunk model of count and carry from the requirement text
  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic [W-1:0] acc, input bit en,
                                output logic cy, output int n);
    logic [W-1:0] s, m, r, x;
    logic p, neg, act;
    logic [W:0] t;
    s = en ? acc : '0; m = a; r = b; p = 1'b0; cy = 1'b0; n = 0;
    while (n < W / 2 && !((r == '0 && !p) || (r == '1 && p))) begin
      act = 1'b1; neg = 1'b0; x = '0;
      case ({r[1:0], p})
        3'b001, 3'b010: x = m;
        3'b011:         x = m << 1;
        3'b100:         begin x = ~(m << 1); neg = 1'b1; end
        3'b101, 3'b110: begin x = ~m; neg = 1'b1; end
        default:        act = 1'b0;
      endcase
      if (act) begin
        t = {1'b0, s} + {1'b0, x} + {{W{1'b0}}, neg};
        s = t[W-1:0]; cy = t[W];
      end
      p = r[1];
      r = {{2{r[W-1]}}, r[W-1:2]};
      m = m << 2;
      n++;
    end
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] acc, input bit en, input bit poke);
    logic [W-1:0] exp_res;
    logic exp_cy;
    int exp_n, lat;
    exp_res = a * b + (en ? acc : '0);
    model(a, b, acc, en, exp_cy, exp_n);
    @(negedge clk);
    mcand_i = a; mplier_i = b; acc_i = acc; acc_en_i = en; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    mcand_i = ~a; mplier_i = $urandom; acc_i = ~acc;
    chk(busy_o == 1'b1, "R5 busy after start", W'(busy_o), W'(1));
    lat = 0;
    while (!done_o && lat < 40) begin
      if (poke && lat == 0) start_i = 1'b1; // R6: start while busy
      @(posedge clk);
      lat++;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(result_o == exp_res, poke ? "R6 result with mid-run start" : (en ? "R1 mac result" : "R1/R8 mul result"),
        result_o, exp_res);
    chk(int'(cycles_o) == exp_n, "R3 cycle count", W'(cycles_o), W'(exp_n));
    chk(lat == exp_n + 1, "R2 latency", W'(lat), W'(exp_n + 1));
    chk(carry_o == exp_cy, "R4 carry", W'(carry_o), W'(exp_cy));
    chk(busy_o == 1'b0, "R5 idle with done", W'(busy_o), W'(0));
    @(negedge clk);
    chk(done_o == 1'b0, "R5 done one cycle", W'(done_o), W'(0));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    chk(busy_o == 0 && done_o == 0 && carry_o == 0, "R7 reset flags",
        W'({busy_o, done_o, carry_o}), W'(0));
    chk(result_o == '0, "R7 reset result", result_o, '0);
    chk(cycles_o == '0, "R7 reset cycles", W'(cycles_o), W'(0));
    rst = 1'b0;

    // Directed corners
    run_op(32'd12345, 32'd0, 32'd0, 1'b0, 1'b0);          // R3 zero: 0 chunks
    run_op(32'd7, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b0);       // R3 -1: 1 chunk
    run_op(32'h1234_5678, 32'h8000_0000, 32'd0, 1'b0, 1'b0); // R3 full 16
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5, 1'b1, 1'b0);
    run_op(32'h8000_0000, 32'h8000_0000, 32'hDEAD_BEEF, 1'b1, 1'b0);
    run_op(32'd3, 32'd5, 32'hFFFF_FFFF, 1'b0, 1'b0);       // R8 acc ignored
    run_op(32'd9, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b0);
    run_op(32'hABCD_0123, 32'h0F0F_0F0F, 32'd0, 1'b0, 1'b1); // R6

    // Constrained random mix
    for (int i = 0; i < 80; i++) begin
      logic [W-1:0] a, b, c;
      int sh;
      a = $urandom; c = $urandom; b = $urandom;
      sh = $urandom_range(0, 31);
      if (i % 3 == 0) b = $signed(b) >>> sh;
      run_op(a, b, c, bit'($urandom_range(0, 1)), (i % 10) == 5);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule